// File: doc/BRIEF.md
# Software Watchdog Timer with Two-Step Service

This block watches that software is still running. Once enabled, a counter advances on every qualified clock tick. Software has to restart that counter before it reaches the selected limit. It does so by writing two fixed byte values to a service register, one after the other. If the limit is reached first, the block emits a one-cycle reset request. The reset sequencing that acts on this request lies outside the block.

A small control register selects the limit and holds the enable and debug-freeze options. That register accepts only its first write after reset, so stray code cannot disable or retune the watchdog later. A limit chosen in the control register only takes effect at the next completed service. The prescale and step exponents are parameters. The default values give limits from 2^9 to 2^24 ticks.

Top module: `wdg_top`

## Requirements
- R1: After reset, `rst_req` is 0 and the control register reads back as the parameter `CTRL_RST`, whose default is 8'h01. The counter starts from zero, so with the reset selection the first request follows exactly one full period of ticks.
- R2: The control byte has these fields: bit 0 enable, bit 1 freeze-enable, bit 2 prescale select `p`, bits 4:3 timing select `t`. The period in ticks is 2^(BASE_LOG2 + STEP_LOG2*t), multiplied by 2^PRE_LOG2 when `p`=1. With the defaults, {p,t} = 000..111 give 2^9, 2^11, 2^13, 2^15, 2^18, 2^20, 2^22 and 2^24.
- R3: A service register write (`wr_sel`=1) of 8'hAA that follows an earlier 8'h55 write restarts the counter and the prescaler at zero.
- R4: Any number of other service writes and idle cycles may fall between the 8'h55 and the 8'hAA, including repeated 8'h55 writes. Service writes of values other than 8'h55 and 8'hAA leave the pending sequence as it was.
- R5: An 8'hAA write with no 8'h55 pending does not restart the counter. A completed service clears the pending 8'h55.
- R6: The control register (`wr_sel`=0) takes only the first write after reset. Later writes are ignored. With `rd_sel`=0 it can be read at any time.
- R7: With `rd_sel`=1, `rd_data` reads 8'h00.
- R8: A new {p,t} written to the control register governs the period only from the next completed service. Until then, the previous selection stays in force, and it also stays in force across timeouts.
- R9: While `freeze`=1 and freeze-enable is 1, the counter holds. With freeze-enable 0, `freeze` has no effect.
- R10: The counter advances only in cycles where `tick_en`=1.
- R11: With enable 0, the counter stays at zero and no reset request is issued.
- R12: On a timeout, `rst_req` is high for exactly one cycle, in the cycle after the tick that completes the period. The counter then restarts from zero with the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock-enable tick for the counter |
| freeze | input | 1 | Debug freeze request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 service |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 service |
| rd_data | output | 8 | Read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench measures how many qualified ticks pass between a chosen starting point and the reset request. A plain 8'h55/8'hAA pair gives a full period. An unarmed 8'hAA, or an 8'hAA after a completed service, gives only the remainder of the period, which separates a real restart from a write that is ignored. The same sequence with foreign values and repeated 8'h55 writes mixed in shows that the pending state survives them.

Freeze windows and sparse tick patterns are run with freeze-enable both set and clear. Counting both ticks and cycles then shows whether held cycles were skipped. Several {p,t} codes, and a second control write, check the period table, write-once protection and the deferred switch to a new period.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam logic [7:0] SVC_ARM  = 8'h55;
   localparam logic [7:0] SVC_FIRE = 8'hAA;

   typedef struct packed {
      logic [2:0] spare;
      logic [1:0] tsel;
      logic       pre;
      logic       frz_en;
      logic       en;
   } wdg_ctrl_t;
endpackage

// File: rtl/wdg_seq.sv
module wdg_seq
   import wdg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       svc_stb,
   input  logic [7:0] svc_data,
   output logic       svc_hit
);
   logic armed_q;

   assign svc_hit = svc_stb && armed_q && (svc_data == SVC_FIRE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (svc_hit)
         armed_q <= 1'b0;
      else if (svc_stb && svc_data == SVC_ARM)
         armed_q <= 1'b1;
   end
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
   parameter int PRE_LOG2 = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic pulse
);
   generate
      if (PRE_LOG2 == 0) begin : g_bypass
         assign pulse = step;
      end else begin : g_div
         logic [PRE_LOG2-1:0] div_q;
         assign pulse = step && (&div_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (clr)
               div_q <= '0;
            else if (step)
               div_q <= div_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
   parameter int BASE_LOG2 = 9,
   parameter int STEP_LOG2 = 2,
   parameter int CNT_W     = BASE_LOG2 + 3 * STEP_LOG2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       adv,
   input  logic [1:0] tsel,
   output logic       expire
);
   localparam int SH_W = $clog2(CNT_W + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [SH_W-1:0]  sh;
   logic [CNT_W:0]   lim;
   logic [CNT_W-1:0] term;

   always_comb begin
      sh     = SH_W'(BASE_LOG2) + SH_W'(STEP_LOG2) * SH_W'(tsel);
      lim    = {{CNT_W{1'b0}}, 1'b1} << sh;
      term   = CNT_W'(lim - (CNT_W + 1)'(1));
      expire = adv && !clr && (cnt_q == term);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || expire)
         cnt_q <= '0;
      else if (adv)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
   import wdg_pkg::*;
#(
   parameter int         BASE_LOG2 = 9,
   parameter int         STEP_LOG2 = 2,
   parameter int         PRE_LOG2  = 9,
   parameter logic [7:0] CTRL_RST  = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       freeze,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   input  logic       rd_sel,
   output logic [7:0] rd_data,
   output logic       rst_req
);
   localparam int CNT_W = BASE_LOG2 + 3 * STEP_LOG2;

   generate
      if (BASE_LOG2 < 1 || STEP_LOG2 < 1 || PRE_LOG2 < 0) begin : g_bad_cfg
         $error("wdg_top: exponents out of range");
      end
   endgenerate

   wdg_ctrl_t  ctrl_q;
   logic       lock_q;
   logic [2:0] act_q;
   logic       rst_req_q;
   logic       svc_hit, pre_pulse, expire;
   logic       run, adv, clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= wdg_ctrl_t'(CTRL_RST);
         lock_q <= 1'b0;
      end else if (wr_en && !wr_sel && !lock_q) begin
         ctrl_q <= wdg_ctrl_t'(wr_data);
         lock_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= CTRL_RST[4:2];
      else if (svc_hit)
         act_q <= {ctrl_q.tsel, ctrl_q.pre};
   end

   wdg_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .svc_stb  (wr_en && wr_sel),
      .svc_data (wr_data),
      .svc_hit  (svc_hit)
   );

   assign run = ctrl_q.en && tick_en && !(freeze && ctrl_q.frz_en);
   assign clr = svc_hit || !ctrl_q.en;

   wdg_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr || expire),
      .step  (run && act_q[0]),
      .pulse (pre_pulse)
   );

   assign adv = run && (act_q[0] ? pre_pulse : 1'b1);

   wdg_count #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .adv    (adv),
      .tsel   (act_q[2:1]),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rst_req_q <= 1'b0;
      else
         rst_req_q <= expire;
   end

   assign rst_req = rst_req_q;
   assign rd_data = rd_sel ? 8'h00 : ctrl_q;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
   parameter int CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rst_req,
   input logic             tick_en,
   input logic             freeze,
   input logic             ctrl_en,
   input logic             frz_en,
   input logic             lock,
   input logic [7:0]       ctrl_val,
   input logic             svc_hit,
   input logic [CNT_W-1:0] cnt
);
   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> !rst_req);

   a_r6_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(ctrl_val));

   a_r3_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
      svc_hit |=> (cnt == '0));

   a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && freeze && frz_en && !svc_hit) |=> $stable(cnt));

   a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !tick_en && !svc_hit) |=> $stable(cnt));
endmodule

bind wdg_top wdg_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rst_req  (rst_req),
   .tick_en  (tick_en),
   .freeze   (freeze),
   .ctrl_en  (ctrl_q.en),
   .frz_en   (ctrl_q.frz_en),
   .lock     (lock_q),
   .ctrl_val (ctrl_q),
   .svc_hit  (svc_hit),
   .cnt      (u_cnt.cnt_q)
);

// File: tb/tb_wdg_top.sv
`timescale 1ns/1ps
module tb_wdg_top;
   localparam int BL = 3, SL = 2, PL = 3;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       tick_en = 1'b0, freeze = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       rst_req;
   int         n_chk = 0, n_fail = 0, cyc = 0;

   always #2.5 clk = ~clk;

   wdg_top #(.BASE_LOG2(BL), .STEP_LOG2(SL), .PRE_LOG2(PL), .CTRL_RST(8'h01)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .rst_req(rst_req)
   );

   function automatic int period(input bit p, input int t);
      return 1 << (BL + SL * t + (p ? PL : 0));
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_en = 1'b0; freeze = 1'b0; wr_en = 1'b0; rd_sel = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input bit sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic service();
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
   endtask

   task automatic run_ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic measure(input int flo, input int fhi, input bit honor, input int div,
                          output int ticks, output int cycles);
      int i = 0;
      ticks = 0;
      while (!rst_req && i < 20000) begin
         tick_en = (i % div == 0);
         freeze  = (i >= flo && i < fhi);
         if (tick_en && !(freeze && honor)) ticks++;
         @(negedge clk);
         i++;
      end
      tick_en = 1'b0; freeze = 1'b0;
      cycles = i;
      @(negedge clk);
      check("R12 pulse width", int'(rst_req), 0);
   endtask

   task automatic t_reset();
      int tk, cy;
      do_reset();
      check("R1 rst_req after reset", int'(rst_req), 0);
      check("R1 ctrl reset value", int'(rd_data), 8'h01);
      rd_sel = 1'b1; #0.1;
      check("R7 service reads zero", int'(rd_data), 0);
      rd_sel = 1'b0;
      measure(0, 0, 0, 1, tk, cy);
      check("R1 R2 first period", tk, period(0, 0));
      measure(0, 0, 0, 1, tk, cy);
      check("R12 restart after timeout", tk, period(0, 0));
   endtask

   task automatic t_sequence();
      int tk, cy;
      run_ticks(5); service();
      measure(0, 0, 0, 1, tk, cy);
      check("R3 service restarts", tk, period(0, 0));
      run_ticks(5); wr(1'b1, 8'hAA);
      measure(0, 0, 0, 1, tk, cy);
      check("R5 unarmed AA ignored", tk, period(0, 0) - 5);
      run_ticks(2); wr(1'b1, 8'h55); run_ticks(3); wr(1'b1, 8'h12);
      wr(1'b1, 8'h55); run_ticks(1); wr(1'b1, 8'hAA);
      measure(0, 0, 0, 1, tk, cy);
      check("R4 interleaved service", tk, period(0, 0));
      service(); run_ticks(4); wr(1'b1, 8'hAA);
      measure(0, 0, 0, 1, tk, cy);
      check("R5 second AA ignored", tk, period(0, 0) - 4);
   endtask

   task automatic t_write_once();
      int tk, cy;
      wr(1'b0, 8'h09);
      check("R6 first write taken", int'(rd_data), 8'h09);
      wr(1'b0, 8'h19);
      check("R6 second write ignored", int'(rd_data), 8'h09);
      measure(0, 0, 0, 1, tk, cy);
      check("R8 old period before service", tk, period(0, 0));
      service();
      measure(0, 0, 0, 1, tk, cy);
      check("R8 R2 new period after service", tk, period(0, 1));
   endtask

   task automatic t_ratio(input logic [7:0] c, input bit p, input int t);
      int tk, cy;
      do_reset(); wr(1'b0, c); service();
      measure(0, 0, 0, 1, tk, cy);
      check("R2 period table", tk, period(p, t));
   endtask

   task automatic t_freeze();
      int tk, cy;
      do_reset(); wr(1'b0, 8'h03); service();
      measure(2, 12, 1, 1, tk, cy);
      check("R9 frozen ticks", tk, period(0, 0));
      check("R9 frozen cycles", cy, period(0, 0) + 10);
      do_reset(); wr(1'b0, 8'h01); service();
      measure(2, 12, 0, 1, tk, cy);
      check("R9 freeze ignored cycles", cy, period(0, 0));
   endtask

   task automatic t_tick();
      int tk, cy;
      measure(0, 0, 0, 3, tk, cy);
      check("R10 sparse ticks", tk, period(0, 0));
      check("R10 sparse cycles", cy, 3 * (period(0, 0) - 1) + 1);
   endtask

   task automatic t_disabled();
      int hits = 0;
      do_reset(); wr(1'b0, 8'h00); service();
      tick_en = 1'b1;
      for (int i = 0; i < 4 * period(0, 0); i++) begin
         @(negedge clk);
         if (rst_req) hits++;
      end
      tick_en = 1'b0;
      check("R11 no request when off", hits, 0);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sequence();
      t_write_once();
      t_ratio(8'h05, 1'b1, 0);
      t_ratio(8'h11, 1'b0, 2);
      t_ratio(8'h1D, 1'b1, 3);
      t_freeze();
      t_tick();
      t_disabled();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule